// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

This block wraps a word-organised memory shared by two independent ports, called left and right, that run in one clock domain. Each port has its own address, write data, write control, per-byte lane enables, a pair of chip selects (one active low, one active high) and an output enable. Either port may read or write any word at any time. When both selected ports point at the same word, an arbitration front end names one port the winner and flags the other as busy. A write from the busy port is suppressed, so the two ports can never both change one word in the same cycle.

Each port can be selected only when both of its chip selects are active, so several instances can be stacked for depth with no extra decode. A mode input chooses between master and slave operation. In master mode the block arbitrates and presents its verdict on the busy outputs. In slave mode it does no arbitration of its own: it takes the busy verdict from a master through its busy inputs, so a row of cascaded instances that form a wider word all act on one decision. The full size is 32K words of 16 bits (`ADDR_W` = 15). The default parameter is smaller so that elaboration stays light.

Top module: `dpr_collision_arbiter`

## Requirements
- R1: A word written through one port at any address, including the highest address, is returned unchanged by a later read of that address on the other port.
- R2: `*_lanes` bit 0 guards data bits 7:0 and bit 1 guards bits 15:8. A write changes only the lanes whose bit is 1. A write with no lane bit set changes nothing.
- R3: A port is selected only when `*_cs0_n` is 0 and `*_cs1` is 1. An unselected port writes nothing and does not drive read data.
- R4: When both ports read the same word in the same cycle, both return its contents.
- R5: In master mode, a collision begins when both ports are selected on equal addresses. Busy goes to the port that arrived later, whether it became selected onto the matching address or moved its address onto the other port's address. The rule is the same for both ports.
- R6: When both ports reach the matching address in the same cycle, only the right port is flagged busy.
- R7: While a collision continues, the busy flag stays on the same port. It drops in the first cycle in which the addresses differ or either port is deselected.
- R8: With `mode_master` = 0 the block does no arbitration. Each port's busy equals its `*_busy_i` input, and `*_busy_o` shows that value.
- R9: A write from a port whose busy is 1 leaves the memory unchanged.
- R10: Read data appears one clock after the read address is presented. `*_rdata_oe` is 1, and `*_rdata` carries data, only when the port was selected for a read in the previous cycle and `*_oe_n` is 0 now. Otherwise `*_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_master | input | 1 | 1: arbitrate internally; 0: take busy from the inputs |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_we | input | 1 | Left write (1) or read (0) |
| l_lanes | input | DATA_W/8 | Left byte lane enables |
| l_cs0_n | input | 1 | Left active-low chip select |
| l_cs1 | input | 1 | Left active-high chip select |
| l_oe_n | input | 1 | Left active-low output enable |
| l_rdata | output | DATA_W | Left read data, zero when not driven |
| l_rdata_oe | output | 1 | Left read data is driven |
| l_busy_i | input | 1 | Left busy from a master (slave mode) |
| l_busy_o | output | 1 | Left busy in effect |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_we | input | 1 | Right write (1) or read (0) |
| r_lanes | input | DATA_W/8 | Right byte lane enables |
| r_cs0_n | input | 1 | Right active-low chip select |
| r_cs1 | input | 1 | Right active-high chip select |
| r_oe_n | input | 1 | Right active-low output enable |
| r_rdata | output | DATA_W | Right read data, zero when not driven |
| r_rdata_oe | output | 1 | Right read data is driven |
| r_busy_i | input | 1 | Right busy from a master (slave mode) |
| r_busy_o | output | 1 | Right busy in effect |

## Verification
On every cycle the assertions check four things: that master mode never flags both ports, that a port already waiting on an address keeps the win against a newcomer, that the flagged port stays fixed for as long as a collision lasts, and that read data is driven only after a read select. They also check that master mode never lets both ports write one word in the same cycle. Only the bench scenarios can show the effects that live in the memory contents. These are lane merging, blocked writes leaving the old word in place, chip-select gating, slave-mode obedience to the busy inputs, and the one-clock read latency seen through the other port.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic {
    LOSER_RIGHT = 1'b0,
    LOSER_LEFT  = 1'b1
  } loser_e;

  typedef struct packed {
    logic sel;
    logic rd;
    logic wr;
  } port_ctl_t;

  localparam int unsigned NPORTS = 2;
  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/dpr_rst_sync.sv
module dpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/dpr_port_decode.sv
module dpr_port_decode
  import dpr_pkg::*;
(
  input  logic      cs0_n,
  input  logic      cs1,
  input  logic      we,
  output port_ctl_t ctl
);
  always_comb begin
    ctl.sel = ~cs0_n & cs1;
    ctl.wr  = ctl.sel & we;
    ctl.rd  = ctl.sel & ~we;
  end
endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] addr [NPORTS],
  input  logic [1:0]        busy_in,
  output logic [1:0]        busy
);
  logic [1:0]        sel_q;
  logic [ADDR_W-1:0] addr_q [NPORTS];
  logic              coll, coll_q, start;
  logic [1:0]        stay, own_busy;
  loser_e            loser_d, loser_q;

  // collision detection and arrival order
  always_comb begin
    coll  = sel[0] & sel[1] & (addr[0] == addr[1]);
    start = coll & ~coll_q;
    for (int i = 0; i < NPORTS; i++) begin
      stay[i] = sel_q[i] & (addr_q[i] == addr[i]);
    end
  end

  // next-state for the loser record
  always_comb begin
    loser_d = loser_q;
    if (start) begin
      if (stay[1] && !stay[0]) loser_d = LOSER_LEFT;
      else                     loser_d = LOSER_RIGHT;
    end
  end

  always_comb begin
    own_busy[0] = coll & (loser_d == LOSER_LEFT);
    own_busy[1] = coll & (loser_d == LOSER_RIGHT);
    busy        = master ? own_busy : busy_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      coll_q  <= 1'b0;
      loser_q <= LOSER_RIGHT;
    end else begin
      sel_q   <= sel;
      coll_q  <= coll;
      loser_q <= loser_d;
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_addr_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q[g] <= '0;
      else if (sel[g]) addr_q[g] <= addr[g];
    end
  end

  // R6: only one port may lose in master mode
  a_r6_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
    master |-> !(own_busy[0] && own_busy[1]));

  // R5: a port that held the address wins against a newcomer
  a_r5_holder_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (master && coll && !coll_q && stay[0] && !stay[1]) |-> (own_busy[1] && !own_busy[0]));

  // R7: the flagged port does not change during a continuing collision
  a_r7_winner_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (master && coll && $past(coll) && $past(master) && $past(rst_n)) |-> $stable(own_busy));
endmodule

// File: rtl/dpr_array.sv
module dpr_array
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic [1:0]               wstb,
  input  logic [1:0]               rstb,
  input  logic [ADDR_W-1:0]        addr  [NPORTS],
  input  logic [DATA_W-1:0]        wdata [NPORTS],
  input  logic [DATA_W/LANE_W-1:0] lanes [NPORTS],
  output logic [DATA_W-1:0]        rdata [NPORTS]
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // port 1 is applied after port 0, so it prevails if both ever write one word
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORTS; p++) begin
      for (int b = 0; b < LANES; b++) begin
        if (wstb[p] && lanes[p][b]) begin
          mem[addr[p]][b*LANE_W +: LANE_W] <= wdata[p][b*LANE_W +: LANE_W];
        end
      end
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_read
    always_ff @(posedge clk) begin
      if (rstb[g]) rdata[g] <= mem[addr[g]];
    end
  end
endmodule

// File: rtl/dpr_collision_arbiter.sv
module dpr_collision_arbiter
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_master,
  input  logic [ADDR_W-1:0]        l_addr,
  input  logic [DATA_W-1:0]        l_wdata,
  input  logic                     l_we,
  input  logic [DATA_W/8-1:0]      l_lanes,
  input  logic                     l_cs0_n,
  input  logic                     l_cs1,
  input  logic                     l_oe_n,
  output logic [DATA_W-1:0]        l_rdata,
  output logic                     l_rdata_oe,
  input  logic                     l_busy_i,
  output logic                     l_busy_o,
  input  logic [ADDR_W-1:0]        r_addr,
  input  logic [DATA_W-1:0]        r_wdata,
  input  logic                     r_we,
  input  logic [DATA_W/8-1:0]      r_lanes,
  input  logic                     r_cs0_n,
  input  logic                     r_cs1,
  input  logic                     r_oe_n,
  output logic [DATA_W-1:0]        r_rdata,
  output logic                     r_rdata_oe,
  input  logic                     r_busy_i,
  output logic                     r_busy_o
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic              rst_s_n;
  port_ctl_t         ctl   [NPORTS];
  logic [1:0]        sel, busy, wstb, rstb, rd_q, oe_n, drive;
  logic [1:0]        cs0_n, cs1, we;
  logic [ADDR_W-1:0] addr  [NPORTS];
  logic [DATA_W-1:0] wdata [NPORTS];
  logic [DATA_W-1:0] arr_q [NPORTS];
  logic [LANES-1:0]  lanes [NPORTS];

  always_comb begin
    cs0_n    = {r_cs0_n, l_cs0_n};
    cs1      = {r_cs1, l_cs1};
    we       = {r_we, l_we};
    oe_n     = {r_oe_n, l_oe_n};
    addr[0]  = l_addr;   addr[1]  = r_addr;
    wdata[0] = l_wdata;  wdata[1] = r_wdata;
    lanes[0] = l_lanes;  lanes[1] = r_lanes;
  end

  dpr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    dpr_port_decode u_decode (
      .cs0_n (cs0_n[g]),
      .cs1   (cs1[g]),
      .we    (we[g]),
      .ctl   (ctl[g])
    );

    always_comb begin
      sel[g]   = ctl[g].sel;
      wstb[g]  = ctl[g].wr & ~busy[g];
      rstb[g]  = ctl[g].rd;
      drive[g] = rd_q[g] & ~oe_n[g];
    end

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) rd_q[g] <= 1'b0;
      else          rd_q[g] <= ctl[g].rd;
    end
  end

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arbiter (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .master  (mode_master),
    .sel     (sel),
    .addr    (addr),
    .busy_in ({r_busy_i, l_busy_i}),
    .busy    (busy)
  );

  dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .wstb  (wstb),
    .rstb  (rstb),
    .addr  (addr),
    .wdata (wdata),
    .lanes (lanes),
    .rdata (arr_q)
  );

  always_comb begin
    l_busy_o   = busy[0];
    r_busy_o   = busy[1];
    l_rdata_oe = drive[0];
    r_rdata_oe = drive[1];
    l_rdata    = drive[0] ? arr_q[0] : '0;
    r_rdata    = drive[1] ? arr_q[1] : '0;
  end

  // R9: in master mode the array never sees two writes to one word
  a_r9_no_write_clash: assert property (@(posedge clk) disable iff (!rst_s_n)
    mode_master |-> !(wstb[0] && wstb[1] && (l_addr == r_addr)));

  // R10: left data is driven only after a read select in the previous cycle
  a_r10_left_drive: assert property (@(posedge clk) disable iff (!rst_s_n)
    l_rdata_oe |-> $past(!l_cs0_n && l_cs1 && !l_we));

  // R10: right data is driven only after a read select in the previous cycle
  a_r10_right_drive: assert property (@(posedge clk) disable iff (!rst_s_n)
    r_rdata_oe |-> $past(!r_cs0_n && r_cs1 && !r_we));
endmodule

// File: tb/test_dpr_collision_arbiter.sv
module test_dpr_collision_arbiter;
  localparam int AW = 11;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n, mode_master;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic [1:0]    l_lanes, r_lanes;
  logic l_we, l_cs0_n, l_cs1, l_oe_n, l_rdata_oe, l_busy_i, l_busy_o;
  logic r_we, r_cs0_n, r_cs1, r_oe_n, r_rdata_oe, r_busy_i, r_busy_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  dpr_collision_arbiter #(.ADDR_W(AW), .DATA_W(DW)) i_dpr_collision_arbiter (.*);

  // fields: port that writes, address, lanes, write data, expected word after the write
  localparam logic [45:0] VEC [6] = '{
    {1'b0, 11'd5,    2'b11, 16'hA1B2, 16'hA1B2},
    {1'b1, 11'd5,    2'b01, 16'hFFCC, 16'hA1CC},
    {1'b0, 11'd5,    2'b10, 16'h3344, 16'h33CC},
    {1'b1, 11'd5,    2'b00, 16'h0000, 16'h33CC},
    {1'b0, 11'h7FF,  2'b11, 16'h1234, 16'h1234},
    {1'b1, 11'd0,    2'b11, 16'hBEEF, 16'hBEEF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input bit p, input logic cs0n, input logic c1, input logic w,
                       input logic oen, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [1:0] ln);
    if (!p) begin
      l_cs0_n = cs0n; l_cs1 = c1; l_we = w; l_oe_n = oen; l_addr = a; l_wdata = d; l_lanes = ln;
    end else begin
      r_cs0_n = cs0n; r_cs1 = c1; r_we = w; r_oe_n = oen; r_addr = a; r_wdata = d; r_lanes = ln;
    end
  endtask

  task automatic desel(input bit p);
    drive(p, 1'b1, 1'b0, 1'b0, 1'b1, '0, '0, 2'b00);
  endtask

  task automatic wr(input bit p, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] ln);
    drive(p, 1'b0, 1'b1, 1'b1, 1'b1, a, d, ln);
    tick();
    desel(p);
  endtask

  task automatic rd_chk(input bit p, input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    drive(p, 1'b0, 1'b1, 1'b0, 1'b0, a, '0, 2'b00);
    tick();
    chk(tag, p ? r_rdata : l_rdata, exp);
    desel(p);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_master = 1'b1; l_busy_i = 1'b0; r_busy_i = 1'b0;
    desel(1'b0); desel(1'b1);
    repeat (3) tick();
    chk("R7 reset busy", {l_busy_o, r_busy_o}, 2'b00);
    chk("R10 reset drive", {l_rdata_oe, r_rdata_oe, l_rdata, r_rdata}, '0);
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 R2: table of writes on one port, read back on the other
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][45], VEC[i][44:34], VEC[i][31:16], VEC[i][33:32]);
      rd_chk(!VEC[i][45], VEC[i][44:34], VEC[i][15:0], $sformatf("R1 R2 vector %0d", i));
    end

    // preload words for later scenarios
    wr(1'b0, 11'd20, 16'h1111, 2'b11);
    wr(1'b0, 11'd50, 16'h2222, 2'b11);
    wr(1'b0, 11'd60, 16'h0F0F, 2'b11);
    wr(1'b0, 11'd70, 16'h7777, 2'b11);
    tick();

    // R3: partially asserted chip selects block writes
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 11'd60, 16'hAAAA, 2'b11); tick();
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 11'd60, 16'hAAAA, 2'b11); tick();
    desel(1'b0); tick();
    rd_chk(1'b1, 11'd60, 16'h0F0F, "R3 write ignored when unselected");
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd60, '0, 2'b00); tick();
    chk("R3 no drive when unselected", {l_rdata_oe, l_rdata}, '0);
    desel(1'b0); tick();

    // R10: output enable gates the read data; write cycle does not drive
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 11'd60, '0, 2'b00); tick();
    chk("R10 oe_n high hides data", {l_rdata_oe, l_rdata}, '0);
    l_oe_n = 1'b0; #1;
    chk("R10 oe_n low shows data", {l_rdata_oe, l_rdata}, {1'b1, 16'h0F0F});
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'd61, 16'h0001, 2'b11); tick();
    chk("R10 no drive after write", l_rdata_oe, 1'b0);
    desel(1'b0); tick();

    // R4: both ports read one word together
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd5, '0, 2'b00);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'd5, '0, 2'b00);
    tick();
    chk("R4 shared read left", l_rdata, 16'h33CC);
    chk("R4 shared read right", r_rdata, 16'h33CC);
    desel(1'b0); desel(1'b1); tick();

    // R5 R9: left holds 20, right arrives and tries to write
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd20, '0, 2'b00); tick();
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'd20, 16'h9999, 2'b11); #1;
    chk("R5 late right is busy", {l_busy_o, r_busy_o}, 2'b01);
    tick();
    chk("R7 busy kept on right", {l_busy_o, r_busy_o}, 2'b01);
    desel(1'b1); #1;
    chk("R7 busy drops on deselect", {l_busy_o, r_busy_o}, 2'b00);
    desel(1'b0); tick();
    rd_chk(1'b0, 11'd20, 16'h1111, "R9 blocked right write");

    // R5: symmetric case, right holds 50, left arrives and writes
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'd50, '0, 2'b00); tick();
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 11'd50, 16'h4444, 2'b11); #1;
    chk("R5 late left is busy", {l_busy_o, r_busy_o}, 2'b10);
    tick();
    desel(1'b0); desel(1'b1); tick();
    rd_chk(1'b1, 11'd50, 16'h2222, "R9 blocked left write");

    // R5 R7: address moves onto the other port's address, then away
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd30, '0, 2'b00);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'd31, '0, 2'b00);
    tick();
    chk("R5 no busy on distinct addresses", {l_busy_o, r_busy_o}, 2'b00);
    l_addr = 11'd31; #1;
    chk("R5 mover left is busy", {l_busy_o, r_busy_o}, 2'b10);
    tick();
    r_addr = 11'd32; #1;
    chk("R7 busy drops on address mismatch", {l_busy_o, r_busy_o}, 2'b00);
    desel(1'b0); desel(1'b1); tick();

    // R6: same-cycle arrival
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd40, '0, 2'b00);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'd40, '0, 2'b00);
    #1;
    chk("R6 tie flags right only", {l_busy_o, r_busy_o}, 2'b01);
    desel(1'b0); desel(1'b1); tick();

    // R8: slave mode follows the busy inputs
    mode_master = 1'b0;
    l_busy_i = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 11'd70, 16'h5555, 2'b11); #1;
    chk("R8 slave busy from input", {l_busy_o, r_busy_o}, 2'b10);
    tick();
    desel(1'b0); l_busy_i = 1'b0; tick();
    rd_chk(1'b1, 11'd70, 16'h7777, "R8 R9 slave write blocked by input");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd80, '0, 2'b00); tick();
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'd80, 16'hAAAA, 2'b11); #1;
    chk("R8 slave no own arbitration", {l_busy_o, r_busy_o}, 2'b00);
    tick();
    desel(1'b0); desel(1'b1); tick();
    rd_chk(1'b0, 11'd80, 16'hAAAA, "R8 slave write allowed");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule